// File: doc/BRIEF.md
# Lane-Partitioned 128-bit SIMD ALU

This block is the integer vector execution slice of a processor datapath. It takes two 128-bit source operands and, under control of an opcode and a lane-size select, treats each operand as sixteen byte lanes, eight halfword lanes or four word lanes. It performs per-lane wrapping addition and subtraction, full-width bitwise logic, and per-lane signed compares that produce all-ones or all-zeros lane masks.

The 128-bit datapath is built as two identical 64-bit halves. The halves run the same lane operation side by side, and no carry or borrow ever passes from one half into the other. Each operation is qualified by a valid strobe and a 5-bit destination register index. Index 0 names a hardwired-zero register, so an operation aimed at it produces no write. The result and its write-enable come out of registers one cycle after the operation is presented.

Top module: `simd_lane_alu`

## Requirements
- R1: The datapath is two independent 64-bit halves (bits 63:0 and 127:64). Nothing carries or borrows from bit 63 into bit 64.
- R2: Opcode encoding is 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 compare-equal, 7 compare-greater. Lane-size encoding is 2'b00 for 8-bit lanes (16 lanes), 2'b01 for 16-bit lanes (8 lanes) and 2'b10 for 32-bit lanes (4 lanes).
- R3: Add produces (a + b) modulo 2^w in every w-bit lane, with no carry across lane boundaries.
- R4: Subtract produces (a - b) modulo 2^w in every w-bit lane, with no borrow across lane boundaries.
- R5: AND, OR, XOR and NOR act bitwise over all 128 bits, and the result does not depend on the lane-size select (2'b00 to 2'b10).
- R6: Compare-equal writes all ones into each lane whose two source lanes are equal, and all zeros into every other lane.
- R7: Compare-greater treats lanes as two's-complement values and writes all ones into a lane when the first source lane is greater than the second, and all zeros otherwise.
- R8: An operation with destination index 0 produces no write: write-enable stays low in the following cycle.
- R9: Lane-size select 2'b11 is reserved. Any operation that uses it produces no write, whatever the opcode.
- R10: With the valid strobe low, no write is produced.
- R11: A qualified operation (valid high, destination nonzero, lane size not reserved) raises write-enable in exactly the next cycle, with the result of that operation.
- R12: After reset, write-enable is low and the result is zero. In any cycle without a write, the result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Qualifies the operation presented this cycle |
| op_i | input | 3 | Operation code (see R2) |
| lane_sz_i | input | 2 | Lane-size select (see R2, R9) |
| dst_idx_i | input | 5 | Destination register index; 0 suppresses the write |
| src_a_i | input | 128 | First source operand |
| src_b_i | input | 128 | Second source operand |
| wr_en_o | output | 1 | Result is valid and should be written |
| result_o | output | 128 | Registered operation result |

## Verification
The bench builds the block with its default parameters: a 128-bit datapath split into 64-bit halves and a smallest lane of 8 bits, so all three lane widths and the reserved select are reachable. At that size a full sweep is cheap. Every opcode is run against every lane-size code over a set of operand patterns that sit on the sign and wrap boundaries: equal operands, most-positive against most-negative, all-ones plus one, and values that carry exactly at lane and half boundaries. Each pattern is repeated with destination 0 and with valid low, so the suppressed-write paths and the hold of the output register are exercised alongside the arithmetic.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOR = 3'd5,
        OP_CEQ = 3'd6,
        OP_CGT = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        LS_BYTE = 2'd0,
        LS_HALF = 2'd1,
        LS_WORD = 2'd2,
        LS_RSVD = 2'd3
    } lane_sz_e;

    function automatic logic op_is_bitwise(input simd_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int LW = 8
) (
    input  simd_op_e        op,
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    output logic [LW-1:0]   y
);
    logic [LW-1:0] sum_w;
    logic [LW-1:0] dif_w;
    logic          eq_w;
    logic          gt_w;

    always_comb begin
        sum_w = a + b;
        dif_w = a - b;
        eq_w  = (a == b);
        gt_w  = ($signed(a) > $signed(b));
        unique case (op)
            OP_ADD:  y = sum_w;
            OP_SUB:  y = dif_w;
            OP_CEQ:  y = {LW{eq_w}};
            OP_CGT:  y = {LW{gt_w}};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_half.sv
module simd_half
    import simd_alu_pkg::*;
#(
    parameter int HALF_W  = 64,
    parameter int MIN_LW  = 8,
    parameter int N_SIZES = 3,
    parameter int SEL_W   = 2
) (
    input  simd_op_e            op,
    input  logic [SEL_W-1:0]    sel,
    input  logic [HALF_W-1:0]   a,
    input  logic [HALF_W-1:0]   b,
    output logic [HALF_W-1:0]   y
);
    logic [N_SIZES-1:0][HALF_W-1:0] lane_res;
    logic [HALF_W-1:0]              bit_res;

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        localparam int LW = MIN_LW << k;
        localparam int NL = HALF_W / LW;
        for (genvar j = 0; j < NL; j++) begin : g_lane
            simd_lane_unit #(.LW(LW)) u_lane (
                .op (op),
                .a  (a[j*LW +: LW]),
                .b  (b[j*LW +: LW]),
                .y  (lane_res[k][j*LW +: LW])
            );
        end
    end

    always_comb begin
        unique case (op)
            OP_AND:  bit_res = a & b;
            OP_OR:   bit_res = a | b;
            OP_XOR:  bit_res = a ^ b;
            OP_NOR:  bit_res = ~(a | b);
            default: bit_res = '0;
        endcase
    end

    always_comb begin
        y = '0;
        if (op_is_bitwise(op)) begin
            y = bit_res;
        end else begin
            for (int k = 0; k < N_SIZES; k++) begin
                if (int'(sel) == k) y = lane_res[k];
            end
        end
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int HALF_W  = 64,
    parameter int MIN_LW  = 8,
    parameter int N_SIZES = 3,
    parameter int SEL_W   = 2,
    parameter int IDX_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op_i,
    input  logic [SEL_W-1:0]    lane_sz_i,
    input  logic [IDX_W-1:0]    dst_idx_i,
    input  logic [DATA_W-1:0]   src_a_i,
    input  logic [DATA_W-1:0]   src_b_i,
    output logic                wr_en_o,
    output logic [DATA_W-1:0]   result_o
);
    localparam int N_HALVES = DATA_W / HALF_W;

    typedef struct packed {
        logic              we;
        logic [DATA_W-1:0] res;
    } alu_state_t;

    alu_state_t        st_d, st_q;
    logic [DATA_W-1:0] comp_w;
    logic              go_w;
    simd_op_e          op_w;

    assign op_w = simd_op_e'(op_i);

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        simd_half #(
            .HALF_W  (HALF_W),
            .MIN_LW  (MIN_LW),
            .N_SIZES (N_SIZES),
            .SEL_W   (SEL_W)
        ) u_half (
            .op  (op_w),
            .sel (lane_sz_i),
            .a   (src_a_i[h*HALF_W +: HALF_W]),
            .b   (src_b_i[h*HALF_W +: HALF_W]),
            .y   (comp_w[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        go_w   = in_valid && (dst_idx_i != '0) && (int'(lane_sz_i) < N_SIZES);
        st_d   = st_q;
        st_d.we = go_w;
        if (go_w) st_d.res = comp_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o  = st_q.we;
    assign result_o = st_q.res;

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
    parameter int DATA_W  = 128,
    parameter int N_SIZES = 3,
    parameter int SEL_W   = 2,
    parameter int IDX_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_i,
    input logic [SEL_W-1:0]  lane_sz_i,
    input logic [IDX_W-1:0]  dst_idx_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic              wr_en_o,
    input logic [DATA_W-1:0] result_o
);
    a_r8_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_idx_i == '0) |=> !wr_en_o);

    a_r9_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(lane_sz_i) >= N_SIZES) |=> !wr_en_o);

    a_r10_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_en_o);

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_idx_i != '0 && int'(lane_sz_i) < N_SIZES) |=> wr_en_o);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> $stable(result_o));

    a_r5_xor_full: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 3'd4 && dst_idx_i != '0 && int'(lane_sz_i) < N_SIZES)
        |=> result_o == ($past(src_a_i) ^ $past(src_b_i)));

    a_r6_equal_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 3'd6 && src_a_i == src_b_i && dst_idx_i != '0
         && int'(lane_sz_i) < N_SIZES) |=> result_o == '1);

endmodule

bind simd_lane_alu simd_lane_alu_chk #(
    .DATA_W  (DATA_W),
    .N_SIZES (N_SIZES),
    .SEL_W   (SEL_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_i      (op_i),
    .lane_sz_i (lane_sz_i),
    .dst_idx_i (dst_idx_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .wr_en_o   (wr_en_o),
    .result_o  (result_o)
);

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op_i = '0;
    logic [1:0]   lane_sz_i = '0;
    logic [4:0]   dst_idx_i = '0;
    logic [127:0] src_a_i = '0;
    logic [127:0] src_b_i = '0;
    logic         wr_en_o;
    logic [127:0] result_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [127:0] exp_res = '0;

    always #4 clk = ~clk;

    simd_lane_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
        .lane_sz_i(lane_sz_i), .dst_idx_i(dst_idx_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .wr_en_o(wr_en_o), .result_o(result_o)
    );

    function automatic logic [127:0] model(input int op, input int ls,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] res, mask, sgn, la, lb, r;
        int w;
        case (op)
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ~(a | b);
            default: ;
        endcase
        w = 8 << ls;
        mask = (128'h1 << w) - 128'h1;
        sgn = 128'h1 << (w - 1);
        res = '0;
        for (int i = 0; i < 128 / w; i++) begin
            la = (a >> (i * w)) & mask;
            lb = (b >> (i * w)) & mask;
            case (op)
                0: r = (la + lb) & mask;
                1: r = (la - lb) & mask;
                6: r = (la == lb) ? mask : '0;
                default: r = ((la ^ sgn) > (lb ^ sgn)) ? mask : '0;
            endcase
            res = res | (r << (i * w));
        end
        return res;
    endfunction

    function automatic logic [127:0] pat(input int k, input logic second);
        case (k)
            0: return second ? 128'h0 : 128'h0;
            1: return second ? {16{8'h01}} : {16{8'hFF}};
            2: return second ? {16{8'h80}} : {16{8'h7F}};
            3: return second ? {16{8'h7F}} : {16{8'h80}};
            4: return second ? 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
                             : 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
            5: return second ? {64'h1, 64'h1} : {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
            6: return second ? {4{32'h8000_0000}} : {4{32'h7FFF_FFFF}};
            7: return second ? {8{16'h0001}} : {8{16'h8000}};
            8: return second ? 128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_9696_6969
                             : 128'h1234_8765_FFFF_0000_8000_7FFF_00FF_FF00;
            default: return second ? {2{64'h0000_0001_0000_0001}} : {2{64'hFFFF_FFFF_FFFF_FFFF}};
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            6: return "R6";
            7: return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(input logic v, input int op, input int ls, input int dst,
                         input logic [127:0] a, input logic [127:0] b, input string tag);
        logic exp_we;
        @(negedge clk);
        in_valid  = v;
        op_i      = op[2:0];
        lane_sz_i = ls[1:0];
        dst_idx_i = dst[4:0];
        src_a_i   = a;
        src_b_i   = b;
        @(posedge clk);
        #2;
        exp_we = v && (dst != 0) && (ls != 3);
        if (exp_we) exp_res = model(op, ls, a, b);
        n_vec++;
        if (wr_en_o !== exp_we || result_o !== exp_res) begin
            n_bad++;
            $display("FAIL %s op=%0d ls=%0d dst=%0d v=%0b: got we=%0b res=%h, expected we=%0b res=%h",
                     tag, op, ls, dst, v, wr_en_o, result_o, exp_we, exp_res);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        n_vec++;
        if (wr_en_o !== 1'b0 || result_o !== '0) begin
            n_bad++;
            $display("FAIL R12 reset: got we=%0b res=%h, expected we=0 res=0", wr_en_o, result_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: word lanes, lower half all ones plus one; upper half untouched by carry
        apply(1'b1, 0, 2, 7, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h1}, "R1/R3");
        apply(1'b1, 1, 2, 7, {64'h0, 64'h0}, {64'h0, 64'h1}, "R1/R4");
        apply(1'b1, 0, 0, 9, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, "R1/R3");

        for (int op = 0; op < 8; op++) begin
            for (int ls = 0; ls < 4; ls++) begin
                for (int k = 0; k < 10; k++) begin
                    string t;
                    t = (ls == 3) ? "R9" : $sformatf("%s/R2/R11", req_of(op));
                    apply(1'b1, op, ls, 1 + k, pat(k, 1'b0), pat(k, 1'b1), t);
                    apply(1'b1, op, ls, 0, pat(k, 1'b1), pat(k, 1'b0), "R8/R12");
                    apply(1'b0, op, ls, 31, pat(k, 1'b1), ~pat(k, 1'b0), "R10/R12");
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule